// File: doc/BRIEF.md
# Exception Recording and Mode Stack Unit

This unit holds the exception state of a small multicycle processor controller: the address of the faulting instruction, the cause of the last exception with the pending interrupt lines, and a status word. The status word carries an interrupt mask and a three-deep stack of kernel/enable mode pairs. The sequencer reports three kinds of event. The first two, an undefined opcode and an arithmetic overflow, are synchronous traps. The third is a set of external interrupt lines. The sequencer also reports whether it currently sits between instructions.

When the unit accepts an exception it raises a PC-load strobe in the same cycle and presents the fixed handler entry address. At the next clock edge it saves the faulting PC, writes the cause code and pushes the mode stack, which puts the processor in kernel mode with interrupts disabled. A return pulse pops the stack. Software reads and writes the three registers through a plain register-select port. It is a register port and not a data stream, so there is no back-pressure: a write takes effect at the next edge, and a read returns the selected register combinationally.

Top module: `exc_unit`

## Requirements
- R1: When an exception is accepted, the exception PC register is loaded with `pc_i - 4` at the next clock edge.
- R2: `pc_load_o` is high in the same cycle that an exception is accepted and low otherwise. `handler_pc_o` always equals 0x8000_0080.
- R3: On acceptance, status bits 5:0 shift left by two with bits 1:0 cleared. Bits 1:0 are the current (k,e) pair, bits 3:2 the previous pair and bits 5:4 the old pair. The mask in bits 15:8 is kept.
- R4: A pulse on `rfe_i` moves status bits 5:2 into bits 3:0 and leaves bits 5:4 unchanged.
- R5: An interrupt is accepted only when `boundary_i` is 1, status bit 0 (e) is 1, and some cause bit n in 15:8 and status bit n are both 1.
- R6: Cause bits 15:10 are set while the matching line of `irq_i` is high and stay set until a software write to cause puts 0 there with the line low. Cause bits 9:8 are software interrupt requests that are written directly.
- R7: The 5-bit code field in cause bits 6:2 receives 0 for an interrupt, 10 for an undefined instruction and 12 for an overflow. Undefined wins over overflow. Software cannot write the code.
- R8: A trap is accepted whenever it is requested, regardless of the boundary, e or the mask. When a trap and an interrupt compete, the trap is taken and the interrupt stays pending.
- R9: A register write or a return pulse in the same cycle as an accepted exception is discarded.
- R10: Reset clears all three registers. This is kernel mode with interrupts disabled and no mask bits set. Select codes are 0 for the exception PC, 1 for cause, 2 for status and 3 for nothing, which reads as zero. Unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | Current, already incremented PC |
| undef_i | input | 1 | Undefined-instruction trap request |
| ovf_i | input | 1 | Arithmetic overflow trap request |
| irq_i | input | 6 | Hardware interrupt lines |
| boundary_i | input | 1 | Sequencer is between instructions |
| rfe_i | input | 1 | Return-from-exception pulse |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Selected register read data |
| pc_load_o | output | 1 | Load the handler address into the PC |
| handler_pc_o | output | 32 | Handler entry address |

## Verification
The bench runs a trap and a pending interrupt in the same cycle. A design with the priority reversed would write code 0, and a design that cleared pending bits on service would lose the interrupt. It pushes the mode stack and pops it again, and checks that the old pair survives. A plain right shift would zero it. It gates interrupts separately by the boundary flag, the e bit and the mask, so a design that ignores any one of these takes a spurious exception. It also collides exceptions with register writes and with the return pulse. A design with the wrong precedence would corrupt the status word.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    SEL_EPC    = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } regsel_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_UNDEF = 2'd1,
    SRC_OVF   = 2'd2,
    SRC_IRQ   = 2'd3
  } exc_src_e;

  localparam logic [4:0] CODE_IRQ   = 5'd0;
  localparam logic [4:0] CODE_UNDEF = 5'd10;
  localparam logic [4:0] CODE_OVF   = 5'd12;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int NLVL = 8
) (
  input  logic            undef_i,
  input  logic            ovf_i,
  input  logic            boundary_i,
  input  logic            ie_i,
  input  logic [NLVL-1:0] pend_i,
  input  logic [NLVL-1:0] mask_i,
  output logic            take_o,
  output exc_src_e        src_o
);
  logic irq_ready;

  assign irq_ready = boundary_i && ie_i && (|(pend_i & mask_i));

  always_comb begin
    src_o = SRC_NONE;
    if (undef_i)        src_o = SRC_UNDEF;
    else if (ovf_i)     src_o = SRC_OVF;
    else if (irq_ready) src_o = SRC_IRQ;
  end

  assign take_o = (src_o != SRC_NONE);
endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg #(
  parameter int XLEN  = 32,
  parameter int NLVL  = 8,
  parameter int DEPTH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic            rfe_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] status_o
);
  localparam int SW      = 2 * DEPTH;
  localparam int MASK_LO = 8;

  logic [SW-1:0]   stack_q, stack_d;
  logic [NLVL-1:0] mask_q;

  always_comb begin
    stack_d = stack_q;
    if (take_i) begin
      stack_d[1:0] = 2'b00;
      for (int p = 1; p < DEPTH; p++) stack_d[2*p +: 2] = stack_q[2*(p-1) +: 2];
    end else if (rfe_i) begin
      for (int p = 0; p < DEPTH - 1; p++) stack_d[2*p +: 2] = stack_q[2*(p+1) +: 2];
    end else if (we_i) begin
      stack_d = wdata_i[SW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stack_q <= '0;
      mask_q  <= '0;
    end else begin
      stack_q <= stack_d;
      if (we_i && !take_i && !rfe_i) mask_q <= wdata_i[MASK_LO +: NLVL];
    end
  end

  always_comb begin
    status_o = '0;
    status_o[SW-1:0]          = stack_q;
    status_o[MASK_LO +: NLVL] = mask_q;
  end

  p_kernel_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (status_o[1:0] == 2'b00) && $stable(mask_q));

  p_old_pair_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_i && !take_i) |=> status_o[SW-1:SW-2] == $past(status_o[SW-1:SW-2]));

  p_write_lost_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && we_i) |=> status_o[MASK_LO +: NLVL] == $past(status_o[MASK_LO +: NLVL]));
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
  import exc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NHW  = 6,
  parameter int NLVL = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NHW-1:0]  irq_i,
  input  logic            take_i,
  input  exc_src_e        src_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [NLVL-1:0] pend_o,
  output logic [XLEN-1:0] cause_o
);
  localparam int NSW    = NLVL - NHW;
  localparam int PEND_LO = 8;
  localparam int HW_LO   = PEND_LO + NSW;

  logic [NHW-1:0] hw_q;
  logic [NSW-1:0] sw_q;
  logic [4:0]     code_q;
  logic           sw_wr;

  assign sw_wr = we_i && !take_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_q   <= '0;
      sw_q   <= '0;
      code_q <= '0;
    end else begin
      hw_q <= (sw_wr ? (hw_q & wdata_i[HW_LO +: NHW]) : hw_q) | irq_i;
      if (sw_wr) sw_q <= wdata_i[PEND_LO +: NSW];
      if (take_i) begin
        case (src_i)
          SRC_UNDEF: code_q <= CODE_UNDEF;
          SRC_OVF:   code_q <= CODE_OVF;
          default:   code_q <= CODE_IRQ;
        endcase
      end
    end
  end

  assign pend_o = {hw_q, sw_q};

  always_comb begin
    cause_o = '0;
    cause_o[PEND_LO +: NLVL] = pend_o;
    cause_o[6:2] = code_q;
  end

  p_pending_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> (hw_q & $past(hw_q)) == $past(hw_q));

  p_ovf_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && src_i == SRC_OVF) |=> cause_o[6:2] == 5'd12);
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          NHW         = 6,
  parameter int          NLVL        = 8,
  parameter int          DEPTH       = 3,
  parameter logic [31:0] HANDLER_PC  = 32'h8000_0080,
  parameter int          INSN_BYTES  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pc_i,
  input  logic            undef_i,
  input  logic            ovf_i,
  input  logic [NHW-1:0]  irq_i,
  input  logic            boundary_i,
  input  logic            rfe_i,
  input  logic            reg_we_i,
  input  logic [1:0]      reg_sel_i,
  input  logic [XLEN-1:0] reg_wdata_i,
  output logic [XLEN-1:0] reg_rdata_o,
  output logic            pc_load_o,
  output logic [XLEN-1:0] handler_pc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  regsel_e         sel;
  logic            take;
  exc_src_e        src;
  logic [NLVL-1:0] pend;
  logic [XLEN-1:0] status, cause;
  logic [XLEN-1:0] epc_q;

  assign sel = regsel_e'(reg_sel_i);

  exc_arbiter #(.NLVL(NLVL)) u_arb (
    .undef_i    (undef_i),
    .ovf_i      (ovf_i),
    .boundary_i (boundary_i),
    .ie_i       (status[0]),
    .pend_i     (pend),
    .mask_i     (status[8 +: NLVL]),
    .take_o     (take),
    .src_o      (src)
  );

  exc_status_reg #(.XLEN(XLEN), .NLVL(NLVL), .DEPTH(DEPTH)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take),
    .rfe_i    (rfe_i),
    .we_i     (reg_we_i && sel == SEL_STATUS),
    .wdata_i  (reg_wdata_i),
    .status_o (status)
  );

  exc_cause_reg #(.XLEN(XLEN), .NHW(NHW), .NLVL(NLVL)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_i   (irq_i),
    .take_i  (take),
    .src_i   (src),
    .we_i    (reg_we_i && sel == SEL_CAUSE),
    .wdata_i (reg_wdata_i),
    .pend_o  (pend),
    .cause_o (cause)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                           epc_q <= '0;
    else if (take)                        epc_q <= pc_i - STEP;
    else if (reg_we_i && sel == SEL_EPC)  epc_q <= reg_wdata_i;
  end

  always_comb begin
    case (sel)
      SEL_EPC:    reg_rdata_o = epc_q;
      SEL_CAUSE:  reg_rdata_o = cause;
      SEL_STATUS: reg_rdata_o = status;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign pc_load_o    = take;
  assign handler_pc_o = XLEN'(HANDLER_PC);

  p_epc_faulting_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |=> epc_q == $past(pc_i) - STEP);

  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_o && !undef_i && !ovf_i) |-> (boundary_i && status[0]));

  p_trap_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_i || ovf_i) |-> pc_load_o);

  p_handler_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
    handler_pc_o == 32'h8000_0080);
endmodule

// File: tb/exc_unit_test.sv
`timescale 1ns/1ps
module exc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc = '0;
  logic        undef = 1'b0, ovf = 1'b0, bnd = 1'b0, rfe = 1'b0, we = 1'b0;
  logic [5:0]  irq = '0;
  logic [1:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, hpc;
  logic        pload;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  exc_unit uut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .undef_i(undef), .ovf_i(ovf),
    .irq_i(irq), .boundary_i(bnd), .rfe_i(rfe), .reg_we_i(we),
    .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pc_load_o(pload), .handler_pc_o(hpc)
  );

  function automatic logic [95:0] mk(bit un, bit ov, logic [5:0] iq, bit bd, bit rf,
                                     bit w, logic [1:0] ws, logic [15:0] wd,
                                     logic [31:0] p, bit ld, logic [1:0] rs,
                                     logic [31:0] rd);
    return {un, ov, iq, bd, rf, w, ws, wd, p, ld, rs, rd};
  endfunction

  localparam int NV = 26;
  localparam logic [95:0] VEC [NV] = '{
    mk(0,0,6'h00,0,0,1,2'd2,16'h0407,32'h000,0,2'd2,32'h0407), // R10 write status
    mk(1,0,6'h00,0,0,0,2'd0,16'h0000,32'h100,1,2'd0,32'h00FC), // R1 R2 undef
    mk(0,0,6'h00,0,0,0,2'd0,16'h0000,32'h000,0,2'd2,32'h041C), // R3 push
    mk(0,0,6'h00,0,0,0,2'd0,16'h0000,32'h000,0,2'd1,32'h0028), // R7 code 10
    mk(0,0,6'h00,0,1,0,2'd0,16'h0000,32'h000,0,2'd2,32'h0417), // R4 pop
    mk(0,0,6'h01,0,0,0,2'd0,16'h0000,32'h000,0,2'd1,32'h0428), // R6 pending
    mk(0,0,6'h01,0,0,0,2'd0,16'h0000,32'h200,0,2'd1,32'h0428), // R5 no boundary
    mk(0,0,6'h01,1,0,0,2'd0,16'h0000,32'h300,1,2'd0,32'h02FC), // R5 irq taken
    mk(0,0,6'h00,0,0,0,2'd0,16'h0000,32'h000,0,2'd1,32'h0400), // R6 R7 sticky, code 0
    mk(0,0,6'h00,0,0,0,2'd0,16'h0000,32'h000,0,2'd2,32'h041C), // R3
    mk(0,0,6'h00,0,0,1,2'd1,16'h0000,32'h000,0,2'd1,32'h0000), // R6 clear
    mk(1,1,6'h00,0,0,0,2'd0,16'h0000,32'h404,1,2'd1,32'h0028), // R7 undef over ovf
    mk(0,1,6'h00,0,0,0,2'd0,16'h0000,32'h504,1,2'd1,32'h0030), // R7 ovf code 12
    mk(0,0,6'h00,0,0,0,2'd0,16'h0000,32'h000,0,2'd0,32'h0500), // R1
    mk(0,0,6'h00,0,0,1,2'd2,16'h0401,32'h000,0,2'd2,32'h0401), // R10
    mk(0,0,6'h01,0,0,0,2'd0,16'h0000,32'h000,0,2'd1,32'h0430), // R6
    mk(0,1,6'h00,1,0,0,2'd0,16'h0000,32'h604,1,2'd1,32'h0430), // R8 trap first
    mk(0,0,6'h00,1,0,1,2'd2,16'h0001,32'h000,0,2'd2,32'h0001), // R5 e=0 blocks
    mk(0,0,6'h00,1,0,0,2'd0,16'h0000,32'h000,0,2'd1,32'h0430), // R5 mask blocks
    mk(1,0,6'h00,0,0,1,2'd2,16'hFFFF,32'h704,1,2'd2,32'h0004), // R9 write lost
    mk(0,0,6'h00,0,0,1,2'd1,16'h0100,32'h000,0,2'd1,32'h0128), // R6 soft pend
    mk(0,0,6'h00,0,0,1,2'd2,16'h0101,32'h000,0,2'd2,32'h0101), // R10
    mk(0,0,6'h00,1,0,0,2'd0,16'h0000,32'h804,1,2'd1,32'h0100), // R5 soft irq
    mk(1,0,6'h00,0,1,0,2'd0,16'h0000,32'h904,1,2'd2,32'h0110), // R9 rfe lost
    mk(0,0,6'h00,0,0,0,2'd0,16'h0000,32'h000,0,2'd0,32'h0900), // R1
    mk(0,0,6'h00,0,0,0,2'd0,16'h0000,32'h000,0,2'd3,32'h0000)  // R10 sel 3
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    undef = 0; ovf = 0; irq = '0; bnd = 0; rfe = 0; we = 0; sel = '0; wdata = '0; pc = '0;
  endtask

  task automatic read_reg(logic [1:0] s, string req, logic [31:0] exp);
    sel = s; #0.5;
    check(req, rdata, exp);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    read_reg(2'd0, "R10 epc reset", 32'h0);
    read_reg(2'd1, "R10 cause reset", 32'h0);
    read_reg(2'd2, "R10 status reset", 32'h0);
    check("R2 handler", hpc, 32'h8000_0080);
    check("R2 idle strobe", {31'b0, pload}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [95:0] v;
      v = VEC[i];
      @(negedge clk);
      {undef, ovf, irq, bnd, rfe, we, sel} = v[95:83];
      wdata = {16'h0, v[82:67]};
      pc    = v[66:35];
      #0.5;
      check($sformatf("R2 strobe step %0d", i), {31'b0, pload}, {31'b0, v[34]});
      @(posedge clk); #0.5;
      idle();
      sel = v[33:32]; #0.5;
      check($sformatf("vector step %0d", i), rdata, v[31:0]);
    end

    @(negedge clk);
    we = 1; sel = 2'd2; wdata = 32'h0000_0403;
    @(posedge clk); #0.5; idle();
    rst_n = 1'b0;
    @(posedge clk); #0.5;
    read_reg(2'd2, "R10 status after reset", 32'h0);
    read_reg(2'd0, "R10 epc after reset", 32'h0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule